// File: doc/BRIEF.md
# Reseedable Pattern Generator with Seed Shadow

This block produces stimulus for many short parallel scan chains in a deterministic logic self-test. A long linear-feedback shift register (LFSR) steps once per shift cycle. A combinational XOR network spreads its state across the chain inputs. A tester streams the next seed, together with a count of how many patterns that seed must cover, into a side register a few bits per clock. This load runs while the current patterns are still shifting.

A small controller counts shift cycles and patterns. At the last shift cycle of the final pattern of a set, it copies the waiting seed into the LFSR on the same clock edge. No shift cycle is lost, and the side register is free to accept the following seed at once. If a seed is due and has not fully arrived, the controller flags the problem and retries at the next pattern boundary. A self-test mode links the side register, the LFSR and the controller counters into one serial chain, so the generator's own state can be scanned.

Top module: `reseed_prpg`

## Requirements
- R1: After synchronous reset the LFSR holds all ones, the side register is empty (`seed_full` low), the shift and pattern counters are zero, and `seed_xfer` and `seed_err` are low.
- R2: In each cycle with `run` high and `test_mode` low, and no seed transfer, the LFSR state `s` becomes `{s[W-2:0], f}`, where `f` is the XOR of state bits 255, 253, 250 and 245 at default parameters. With `run` low the state holds.
- R3: `chain_in[j]` is the XOR of LFSR bits `(13*j) mod W`, `(13*j+71) mod W` and `(13*j+149) mod W` at default parameters. It is taken from the current state with no register in between.
- R4: Each cycle with `seed_valid` high while the side register is not full shifts `seed_beat` in at the low end. After 33 accepted beats `seed_full` is high. Beats offered while the register is full and no transfer is happening are ignored.
- R5: A pattern boundary is a `run` cycle in which the shift counter reads 39 (chain length 40). At a boundary where the pattern counter is zero and the side register is full, the LFSR loads the low 256 side-register bits on that edge. The new pattern starts on the next cycle with no idle cycle, and `seed_xfer` is high for that next cycle.
- R6: The side-register bits [263:256], which are the first beat sent, load the pattern counter at a transfer. A seed with count `c` drives `c+1` consecutive patterns. The LFSR runs freely across the boundaries inside the set.
- R7: At a transfer edge the side register empties. A beat offered in that same cycle is kept as the first beat of the next seed.
- R8: At a boundary where the pattern counter is zero and the side register is not full, `seed_err` is high for one cycle. The LFSR keeps stepping, and the transfer is retried at the next boundary.
- R9: Loading the same seed twice yields identical `chain_in` sequences for the patterns that follow each transfer.
- R10: With `test_mode` high, all generator state forms one serial chain from `st_si` to `st_so` of length 540 at default parameters. The order is side register (fill count low end first), then LFSR, then controller counters. No transfer or error pulse occurs in this mode.
- R11: The chain length parameter must be at least the number of beats needed to fill the side register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Shift enable: LFSR steps and shift counter advances |
| test_mode | input | 1 | Self-test rechaining of all generator state |
| seed_valid | input | 1 | Beat on `seed_beat` is offered |
| seed_beat | input | SI_W (8) | Serial seed data from the tester |
| st_si | input | 1 | Self-test scan input |
| chain_in | output | N_CH (16) | Scan chain input bits from the phase shifter |
| seed_full | output | 1 | Side register holds a complete seed |
| seed_xfer | output | 1 | A seed entered the LFSR on the previous edge |
| seed_err | output | 1 | A seed was due but incomplete on the previous edge |
| st_so | output | 1 | Self-test scan output |

## Verification
A corrupted LFSR bit or a wrong feedback tap changes `chain_in` within a few cycles, because every state bit reaches the chain inputs within one rotation of the register. A miscounted shift or pattern counter moves the `seed_xfer` pulse off its multiple of 40 cycles, and the following patterns then diverge from the seed-derived sequence at once. An error in the side register shows as a `seed_full` mismatch during loading, or as a wrong first pattern after the next transfer. A broken self-test link shows as a wrong delay between `st_si` and `st_so`.

// File: rtl/prpg_pkg.sv
package prpg_pkg;

  // Position of one phase-shifter tap for chain j.
  function automatic int tap_pos(input int j, input int stride, input int off, input int w);
    return (j * stride + off) % w;
  endfunction

  // Beats needed to fill a side register holding seed plus count.
  function automatic int beats_for(input int w, input int cnt_w, input int si_w);
    return (w + cnt_w + si_w - 1) / si_w;
  endfunction

endpackage

// File: rtl/prpg_shadow.sv
module prpg_shadow #(
  parameter int W     = 256,
  parameter int CNT_W = 8,
  parameter int SI_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_valid,
  input  logic [SI_W-1:0]  beat,
  input  logic             take,
  input  logic             st_en,
  input  logic             st_in,
  output logic [W-1:0]     seed_word,
  output logic [CNT_W-1:0] seed_cnt,
  output logic             full,
  output logic             st_out
);
  localparam int BEATS = prpg_pkg::beats_for(W, CNT_W, SI_W);
  localparam int SH_W  = BEATS * SI_W;
  localparam int FW    = $clog2(BEATS + 1);

  logic [SH_W-1:0] sh_q;
  logic [FW-1:0]   fill_q;
  logic            accept;

  assign full   = (fill_q == FW'(BEATS));
  assign accept = beat_valid && (!full || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (st_en) begin
      {sh_q, fill_q} <= {sh_q[SH_W-2:0], fill_q, st_in};
    end else begin
      if (accept) sh_q <= {sh_q[SH_W-SI_W-1:0], beat};
      if (take)        fill_q <= accept ? FW'(1) : '0;
      else if (accept) fill_q <= fill_q + 1'b1;
    end
  end

  assign seed_word = sh_q[W-1:0];
  assign seed_cnt  = sh_q[W +: CNT_W];
  assign st_out    = sh_q[SH_W-1];

  // R4: a full register stays full until a transfer takes it
  a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && !take && !st_en) |=> full);

  // R7: after a transfer at most the single beat of that cycle remains
  a_r7_reuse_at_once: assert property (@(posedge clk) disable iff (rst)
    (take && !st_en) |=> (fill_q <= FW'(1)));
endmodule

// File: rtl/prpg_lfsr.sv
module prpg_lfsr #(
  parameter int W         = 256,
  parameter int N_CH      = 16,
  parameter int T0        = 255,
  parameter int T1        = 253,
  parameter int T2        = 250,
  parameter int T3        = 245,
  parameter int PS_STRIDE = 13,
  parameter int PS_OFF1   = 71,
  parameter int PS_OFF2   = 149
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic            load_en,
  input  logic [W-1:0]    load_val,
  input  logic            st_en,
  input  logic            st_in,
  output logic [W-1:0]    state,
  output logic [N_CH-1:0] chain_bits,
  output logic            st_out
);
  localparam logic [W-1:0] ONE_B   = W'(1);
  localparam logic [W-1:0] FB_MASK = (ONE_B << T0) | (ONE_B << T1) | (ONE_B << T2) | (ONE_B << T3);

  always_ff @(posedge clk) begin
    if (rst)          state <= '1;
    else if (st_en)   state <= {state[W-2:0], st_in};
    else if (load_en) state <= load_val;
    else if (step_en) state <= {state[W-2:0], ^(state & FB_MASK)};
  end

  assign st_out = state[W-1];

  // Combinational phase shifter: three taps per chain
  for (genvar j = 0; j < N_CH; j++) begin : g_ps
    localparam int P0 = prpg_pkg::tap_pos(j, PS_STRIDE, 0, W);
    localparam int P1 = prpg_pkg::tap_pos(j, PS_STRIDE, PS_OFF1, W);
    localparam int P2 = prpg_pkg::tap_pos(j, PS_STRIDE, PS_OFF2, W);
    assign chain_bits[j] = state[P0] ^ state[P1] ^ state[P2];
  end

  // R2: idle cycles leave the state untouched
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!st_en && !load_en && !step_en) |=> $stable(state));

  // R2: a step moves every bit one place up
  a_r2_step_shifts: assert property (@(posedge clk) disable iff (rst)
    (!st_en && !load_en && step_en) |=> (state[W-1:1] == $past(state[W-2:0])));
endmodule

// File: rtl/prpg_ctrl.sv
module prpg_ctrl #(
  parameter int CHAIN_LEN = 40,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             st_en,
  input  logic             st_in,
  input  logic             full,
  input  logic [CNT_W-1:0] seed_cnt,
  output logic             take,
  output logic             seed_xfer,
  output logic             seed_err,
  output logic             st_out
);
  localparam int SC_W = $clog2(CHAIN_LEN);

  logic [SC_W-1:0]  shift_q;
  logic [CNT_W-1:0] pats_q;
  logic             boundary, miss;

  assign boundary = run && !st_en && (shift_q == SC_W'(CHAIN_LEN - 1));
  assign take     = boundary && (pats_q == '0) && full;
  assign miss     = boundary && (pats_q == '0) && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q   <= '0;
      pats_q    <= '0;
      seed_xfer <= 1'b0;
      seed_err  <= 1'b0;
    end else if (st_en) begin
      {pats_q, shift_q} <= {pats_q[CNT_W-2:0], shift_q, st_in};
      seed_xfer <= 1'b0;
      seed_err  <= 1'b0;
    end else begin
      seed_xfer <= take;
      seed_err  <= miss;
      if (run) shift_q <= boundary ? '0 : shift_q + 1'b1;
      if (take)                             pats_q <= seed_cnt;
      else if (boundary && pats_q != '0)    pats_q <= pats_q - 1'b1;
    end
  end

  assign st_out = pats_q[CNT_W-1];

  // R5: the shift counter wraps to zero right after a boundary
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst || st_en)
    boundary |=> (shift_q == '0));

  // R6: inside a set the pattern count drops by one per boundary
  a_r6_count_down: assert property (@(posedge clk) disable iff (rst || st_en)
    (boundary && pats_q != '0) |=> (pats_q == $past(pats_q) - 1'b1));

  // R8: a missed seed leaves the count at zero so the next boundary retries
  a_r8_retry: assert property (@(posedge clk) disable iff (rst || st_en)
    seed_err |-> (pats_q == '0));
endmodule

// File: rtl/reseed_prpg.sv
module reseed_prpg #(
  parameter int LFSR_W    = 256,
  parameter int CNT_W     = 8,
  parameter int SI_W      = 8,
  parameter int N_CH      = 16,
  parameter int CHAIN_LEN = 40,
  parameter int T0        = 255,
  parameter int T1        = 253,
  parameter int T2        = 250,
  parameter int T3        = 245,
  parameter int PS_STRIDE = 13,
  parameter int PS_OFF1   = 71,
  parameter int PS_OFF2   = 149
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            test_mode,
  input  logic            seed_valid,
  input  logic [SI_W-1:0] seed_beat,
  input  logic            st_si,
  output logic [N_CH-1:0] chain_in,
  output logic            seed_full,
  output logic            seed_xfer,
  output logic            seed_err,
  output logic            st_so
);
  localparam int BEATS = prpg_pkg::beats_for(LFSR_W, CNT_W, SI_W);

  logic [LFSR_W-1:0] seed_word, lfsr_state;
  logic [CNT_W-1:0]  seed_cnt;
  logic              take, sh_so, lf_so;

  prpg_shadow #(.W(LFSR_W), .CNT_W(CNT_W), .SI_W(SI_W)) shadow_i (
    .clk(clk), .rst(rst), .beat_valid(seed_valid && !test_mode), .beat(seed_beat),
    .take(take), .st_en(test_mode), .st_in(st_si),
    .seed_word(seed_word), .seed_cnt(seed_cnt), .full(seed_full), .st_out(sh_so));

  prpg_lfsr #(.W(LFSR_W), .N_CH(N_CH), .T0(T0), .T1(T1), .T2(T2), .T3(T3),
              .PS_STRIDE(PS_STRIDE), .PS_OFF1(PS_OFF1), .PS_OFF2(PS_OFF2)) lfsr_i (
    .clk(clk), .rst(rst), .step_en(run && !test_mode), .load_en(take),
    .load_val(seed_word), .st_en(test_mode), .st_in(sh_so),
    .state(lfsr_state), .chain_bits(chain_in), .st_out(lf_so));

  prpg_ctrl #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .run(run), .st_en(test_mode), .st_in(lf_so),
    .full(seed_full), .seed_cnt(seed_cnt), .take(take),
    .seed_xfer(seed_xfer), .seed_err(seed_err), .st_out(st_so));

  // R11: a whole seed must fit within one pattern's shift
  initial a_r11_len_fits: assert (CHAIN_LEN >= BEATS)
    else $error("chain length %0d below seed beats %0d", CHAIN_LEN, BEATS);

  // R5: the transfer pulse follows an edge on which the waiting seed entered the LFSR
  a_r5_seed_in_lfsr: assert property (@(posedge clk) disable iff (rst)
    seed_xfer |-> (lfsr_state == $past(seed_word)));

  // R10: no transfer or error pulse in self-test
  a_r10_quiet_selftest: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> (!seed_xfer && !seed_err));
endmodule

// File: tb/reseed_prpg_tb_top.sv
module reseed_prpg_tb_top;
  localparam int W = 256, CW = 8, SIW = 8, NCH = 16, LEN = 40;
  localparam int BEATS = (W + CW + SIW - 1) / SIW;
  localparam int SHW = BEATS * SIW;
  localparam int FW = $clog2(BEATS + 1);
  localparam int SCW = $clog2(LEN);
  localparam int CHL = SHW + FW + W + CW + SCW;
  localparam logic [W-1:0] ONE_B = W'(1);
  localparam logic [W-1:0] FBM = (ONE_B << 255) | (ONE_B << 253) | (ONE_B << 250) | (ONE_B << 245);

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, test_mode = 1'b0, seed_valid = 1'b0, st_si = 1'b0;
  logic [SIW-1:0] seed_beat = '0;
  logic [NCH-1:0] chain_in;
  logic seed_full, seed_xfer, seed_err, st_so;

  reseed_prpg dut_i (.clk(clk), .rst(rst), .run(run), .test_mode(test_mode),
    .seed_valid(seed_valid), .seed_beat(seed_beat), .st_si(st_si), .chain_in(chain_in),
    .seed_full(seed_full), .seed_xfer(seed_xfer), .seed_err(seed_err), .st_so(st_so));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // reference model state
  logic [W-1:0]   m_lfsr;
  logic [SHW-1:0] m_sh;
  int m_fill, m_shift, m_pats;
  bit m_xfer, m_err;
  logic [NCH-1:0] pre_chain;
  logic [NCH-1:0] cap [4][LEN];

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & FBM)};
  endfunction

  function automatic logic [NCH-1:0] ps(input logic [W-1:0] s);
    logic [NCH-1:0] r;
    for (int j = 0; j < NCH; j++)
      r[j] = s[(13*j) % W] ^ s[(13*j + 71) % W] ^ s[(13*j + 149) % W];
    return r;
  endfunction

  function automatic logic [SHW-1:0] mk_sh(input logic [W-1:0] seed, input logic [CW-1:0] cnt);
    logic [SHW-1:0] s = '0;
    s[W-1:0] = seed;
    s[W +: CW] = cnt;
    return s;
  endfunction

  function automatic logic [SIW-1:0] beat_of(input logic [SHW-1:0] s, input int k);
    return s[SHW-1-k*SIW -: SIW];
  endfunction

  function automatic logic [W-1:0] rand_seed();
    logic [W-1:0] r;
    for (int i = 0; i < W/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check(chain_in == ps(m_lfsr), "R2/R3/R5/R6 chain_in", W'(chain_in), W'(ps(m_lfsr)));
    check(seed_full == (m_fill == BEATS), "R4/R7 seed_full", W'(seed_full), W'(m_fill == BEATS));
    check(seed_xfer == m_xfer, "R5/R6 seed_xfer", W'(seed_xfer), W'(m_xfer));
    check(seed_err == m_err, "R8 seed_err", W'(seed_err), W'(m_err));
  endtask

  task automatic model_reset();
    m_lfsr = '1; m_sh = '0; m_fill = 0; m_shift = 0; m_pats = 0; m_xfer = 0; m_err = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; run = 1'b0; test_mode = 1'b0; seed_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    compare_all(); // R1
    check(st_so == 1'b0, "R1 counters clear", W'(st_so), '0);
  endtask

  // One clock: drive at negedge, predict, compare at next negedge
  task automatic cyc(input bit r, input bit v, input logic [SIW-1:0] b);
    bit bnd, tk, ms, acc;
    logic [W-1:0] nl; logic [SHW-1:0] ns; int nf, nsh, np;
    pre_chain = chain_in;
    run = r; seed_valid = v; seed_beat = b;
    bnd = r && (m_shift == LEN - 1);
    tk  = bnd && (m_pats == 0) && (m_fill == BEATS);
    ms  = bnd && (m_pats == 0) && (m_fill != BEATS);
    acc = v && ((m_fill != BEATS) || tk);
    nl  = tk ? m_sh[W-1:0] : (r ? step(m_lfsr) : m_lfsr);
    nsh = r ? (bnd ? 0 : m_shift + 1) : m_shift;
    np  = tk ? int'(m_sh[W +: CW]) : ((bnd && m_pats != 0) ? m_pats - 1 : m_pats);
    ns  = acc ? {m_sh[SHW-SIW-1:0], b} : m_sh;
    nf  = tk ? (acc ? 1 : 0) : (acc ? m_fill + 1 : m_fill);
    @(posedge clk);
    @(negedge clk);
    m_lfsr = nl; m_sh = ns; m_fill = nf; m_shift = nsh; m_pats = np; m_xfer = tk; m_err = ms;
    compare_all();
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] sa, sb, sc, sd, t;
    int errs, gap;
    bit hist [CHL + 21];
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R8: run a full pattern with nothing loaded
    errs = 0;
    for (int i = 0; i < LEN; i++) begin cyc(1, 0, '0); if (seed_err) errs++; end
    check(errs == 1, "R8 single miss pulse", W'(errs), W'(1));
    for (int i = 0; i < 5; i++) cyc(1, 0, '0);

    do_reset();
    sa = rand_seed(); sb = rand_seed();
    for (int k = 0; k < BEATS; k++) cyc(0, 1, beat_of(mk_sh(sa, 0), k));
    check(seed_full == 1'b1, "R4 full after all beats", W'(seed_full), W'(1));
    cyc(0, 1, 8'hFF); // R4: ignored while full

    // R5/R7/R9: back-to-back single-pattern sets A, B, A, B
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < LEN; i++) begin
        logic [SHW-1:0] nx; bit v; logic [SIW-1:0] b;
        v = 0; b = '0;
        if (i == LEN - 1 && s < 3) begin
          nx = mk_sh(((s + 2) % 2) ? sa : sb, 0); v = 1; b = beat_of(nx, 0);
        end else if (s >= 1 && i < BEATS - 1) begin
          nx = mk_sh(((s + 1) % 2) ? sa : sb, 0); v = 1; b = beat_of(nx, i + 1);
        end
        cyc(1, v, b);
        cap[s][i] = pre_chain;
        if (i == LEN - 1)
          check(seed_xfer == 1'b1, "R5 transfer without stall", W'(seed_xfer), W'(1));
      end
    end
    for (int i = 0; i < LEN; i++)
      check(cap[1][i] == cap[3][i], "R9 same seed same data", W'(cap[3][i]), W'(cap[1][i]));
    errs = 0;
    for (int i = 0; i < LEN; i++) if (cap[1][i] != cap[2][i]) errs++;
    check(errs != 0, "R9 different seeds differ", W'(errs), W'(1));
    t = sa;
    for (int i = 0; i < LEN; i++) begin
      check(cap[1][i] == ps(t), "R3 pattern from seed", W'(cap[1][i]), W'(ps(t)));
      t = step(t);
    end

    // R6: seed with count 2 covers three patterns
    sc = rand_seed(); sd = rand_seed();
    for (int k = 0; k < BEATS; k++) cyc(1, 1, beat_of(mk_sh(sc, 2), k));
    for (int k = BEATS; k < LEN; k++) cyc(1, 0, '0);
    check(seed_xfer == 1'b1, "R6 set C taken", W'(seed_xfer), W'(1));
    gap = 0;
    for (int k = 0; k < BEATS; k++) begin cyc(1, 1, beat_of(mk_sh(sd, 0), k)); gap++; end
    while (!seed_xfer && gap < 500) begin cyc(1, 0, '0); gap++; end
    check(gap == 3 * LEN, "R6 set length", W'(gap), W'(3 * LEN));

    // constrained random mix against the model
    for (int n = 0; n < 4000; n++) begin
      bit r, v; logic [SIW-1:0] b;
      r = ($urandom % 8) != 0;
      v = ($urandom % 3) != 0;
      b = (m_fill == 0 || m_fill == BEATS) ? SIW'($urandom % 3) : SIW'($urandom);
      cyc(r, v, b);
    end

    // R10: self-test chain delay
    test_mode = 1'b1; run = 1'b0; seed_valid = 1'b0;
    for (int n = 1; n <= CHL + 20; n++) begin
      st_si = 1'($urandom);
      hist[n] = st_si;
      @(posedge clk);
      @(negedge clk);
      if (n >= CHL)
        check(st_so == hist[n - CHL + 1], "R10 scan delay", W'(st_so), W'(hist[n - CHL + 1]));
      if (n == CHL)
        check(!seed_xfer && !seed_err, "R10 no pulses", W'({seed_xfer, seed_err}), '0);
    end
    do_reset();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule